// File: doc/BRIEF.md
# Phase-Shifted Dual-Bridge PWM Generator

This block produces the eight gate-drive signals for a converter built from two full bridges that are coupled through a transformer. Each bridge has two legs, and each leg has a high-side and a low-side gate. Both bridges switch at one fixed frequency with a 50% square wave. Bridge 2 lags bridge 1 by a programmable number of clock ticks, and that lag sets the power flow. Software or a control loop writes the lag through a data port and a write strobe. The value waits in a shadow register. It is applied only at a bridge 1 period boundary.

Both bridges run from one time base and start together when `en` rises. The parameter `LAG_STYLE` selects how bridge 2 follows a new lag. In the stretch style, bridge 2 has its own counter. One of its periods is lengthened once by the difference between the new lag and the old one. Every high pulse keeps its width, and the offset stays in place because no resynchronization ever clears it. In the window style, bridge 2 is high while the shared counter lies inside a half-period window that starts at the lag value, so no period register is touched. Each gate has a fixed dead time on its rising edge, and leg B of a bridge is the inverse of leg A.

Top module: `dab_pwm_phase`

## Requirements
- R1: While `rst_n` is low, and from the second clock edge after `en` is sampled low, all eight bits of `gate_o` are 0.
- R2: In steady running, the bridge 1 leg A high gate (`gate_o[0]`) rises once every `PERIOD` cycles and stays high for `PERIOD/2 - DEAD` cycles.
- R3: The gate bit order is: bit 0 is bridge 1 leg A high, bit 1 is bridge 1 leg A low, bit 2 is bridge 1 leg B high, bit 3 is bridge 1 leg B low, and bits 4 to 7 follow the same order for bridge 2. Leg B is the inverse of leg A, so bit 2 always equals bit 1, bit 3 equals bit 0, bit 6 equals bit 5, and bit 7 equals bit 4.
- R4: The high and low gates of a leg are never 1 together. After one of them falls, the other rises exactly `DEAD` cycles later.
- R5: After `en` rises, the first rising edges of `gate_o[0]` and `gate_o[4]` fall on the same cycle, whatever lag has been programmed.
- R6: In steady running with lag value L (0 to `PERIOD-1`), each rise of `gate_o[4]` comes exactly L cycles after the latest rise of `gate_o[0]`. This holds in both styles.
- R7: A write with `phase_din` less than `PERIOD` is stored in the shadow register. A write with `phase_din` of `PERIOD` or more is ignored, and the lag stays as it was.
- R8: A newly written lag changes nothing before the next bridge 1 period boundary. A rise of `gate_o[4]` that falls before that boundary keeps the old lag.
- R9: In the stretch style, a change from lag A to lag B lengthens exactly one bridge 2 period to `PERIOD + ((B - A) mod PERIOD)`. Every other period stays `PERIOD`, and every `gate_o[4]` high pulse stays `PERIOD/2 - DEAD` cycles wide, including during the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the time base, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; its rising edge starts both bridges together |
| phase_wr | input | 1 | Write strobe for the lag value |
| phase_din | input | $clog2(PERIOD) | Lag of bridge 2 behind bridge 1, in clock ticks |
| gate_o | output | 8 | Gate drives, in the bit order given in R3 |

## Verification
`en` is registered once, and each gate is registered once more. The gates therefore go idle two edges after `en` drops. A gate rises `DEAD+1` edges after its raw square wave rises and falls one edge after it falls. Because every gate sees the same delay, the bench measures lags, widths and periods from gate edge to gate edge, so the fixed delay cancels out. A write reaches the shadow register on the next edge. The new lag is applied at the next bridge 1 boundary, within one period. In the stretch style, bridge 2 takes at most two more periods to finish its single long period. The bench waits five periods after each write before it measures a lag. For R8, it measures on the first bridge 2 rise after a write that lands just past a boundary. All outputs are sampled on the falling clock edge.

// File: rtl/dab_pwm_pkg.sv
package dab_pwm_pkg;

  // Variant of the lagging bridge
  typedef enum logic {
    LAG_STRETCH = 1'b0,   // own counter, one stretched period per change
    LAG_WINDOW  = 1'b1    // compare window on the shared counter
  } lag_style_e;

  // (a - b) modulo period, both operands already below period
  function automatic logic [31:0] mod_sub(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic [31:0] period);
    return (a >= b) ? (a - b) : (a + period - b);
  endfunction

  // True while cnt lies in the half period that opens at ph
  function automatic logic in_high_window(input logic [31:0] cnt,
                                          input logic [31:0] ph,
                                          input logic [31:0] period);
    return mod_sub(cnt, ph, period) < (period >> 1);
  endfunction

  // A lag value is accepted only inside one period
  function automatic logic phase_legal(input logic [31:0] v,
                                       input logic [31:0] period);
    return v < period;
  endfunction

endpackage

// File: rtl/dab_ref_timebase.sv
module dab_ref_timebase #(
  parameter int PERIOD = 16000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  output logic [$clog2(PERIOD)-1:0] cnt_o,
  output logic                      wrap_o
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;

  // Last tick of a reference period: the boundary event
  assign wrap_o = run_i && (cnt_q == CW'(PERIOD - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_ref_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(PERIOD));

  assert_ref_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/dab_phase_ctl.sv
module dab_phase_ctl import dab_pwm_pkg::*; #(
  parameter int PERIOD = 16000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic                      wr_i,
  input  logic [$clog2(PERIOD)-1:0] din_i,
  input  logic                      ref_wrap_i,
  input  logic                      busy_i,
  output logic [$clog2(PERIOD)-1:0] ph_act_o,
  output logic [$clog2(PERIOD)-1:0] delta_o,
  output logic                      apply_o
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] shadow_q;
  logic [CW-1:0] act_q;
  logic          take;

  // Move shadow to active only on a boundary with no change in flight
  assign take     = ref_wrap_i && !busy_i && (shadow_q != act_q);
  assign apply_o  = take;
  assign ph_act_o = act_q;
  assign delta_o  = CW'(mod_sub(32'(shadow_q), 32'(act_q), 32'(PERIOD)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr_i && phase_legal(32'(din_i), 32'(PERIOD)))
        shadow_q <= din_i;
      if (!run_i)    act_q <= '0;
      else if (take) act_q <= shadow_q;
    end
  end

  assert_bad_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !phase_legal(32'(din_i), 32'(PERIOD))) |=> (shadow_q == $past(shadow_q)));

  assert_phase_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ref_wrap_i) |=> (act_q == $past(act_q)));

endmodule

// File: rtl/dab_lag_gen.sv
module dab_lag_gen import dab_pwm_pkg::*; #(
  parameter int         PERIOD    = 16000,
  parameter lag_style_e LAG_STYLE = LAG_STRETCH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic [$clog2(PERIOD)-1:0] ref_cnt_i,
  input  logic [$clog2(PERIOD)-1:0] ph_act_i,
  input  logic                      apply_i,
  input  logic [$clog2(PERIOD)-1:0] delta_i,
  output logic                      sq_o,
  output logic                      busy_o
);
  localparam int CW = $clog2(PERIOD);

  generate
    if (LAG_STYLE == LAG_STRETCH) begin : g_stretch
      localparam int C2W = $clog2(2 * PERIOD);

      logic [C2W-1:0] c2_q;
      logic           pend_q;
      logic           str_q;
      logic [CW-1:0]  ext_q;
      logic           nom_end;
      logic           str_end;
      wire            unused_stretch = ^{ref_cnt_i, ph_act_i};

      assign nom_end = (c2_q == C2W'(PERIOD - 1));
      assign str_end = (c2_q == (C2W'(PERIOD - 1) + C2W'(ext_q)));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c2_q <= '0; pend_q <= 1'b0; str_q <= 1'b0; ext_q <= '0;
        end else if (!run_i) begin
          c2_q <= '0; pend_q <= 1'b0; str_q <= 1'b0; ext_q <= '0;
        end else begin
          if (apply_i) begin
            pend_q <= 1'b1;
            ext_q  <= delta_i;
          end
          if (str_q) begin
            if (str_end) begin
              c2_q  <= '0;
              str_q <= 1'b0;
            end else begin
              c2_q <= c2_q + 1'b1;
            end
          end else if (nom_end) begin
            if (pend_q) begin
              c2_q   <= c2_q + 1'b1;
              str_q  <= 1'b1;
              pend_q <= 1'b0;
            end else begin
              c2_q <= '0;
            end
          end else begin
            c2_q <= c2_q + 1'b1;
          end
        end
      end

      // High part is fixed; the stretch lengthens only the low part
      assign sq_o   = run_i && (c2_q < C2W'(PERIOD / 2));
      assign busy_o = pend_q || str_q;

      assert_stretch_from_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(str_q) |-> $past(pend_q));

      assert_stretch_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        str_q |-> !pend_q);

      assert_stretch_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c2_q < C2W'(2 * PERIOD - 1));
    end else begin : g_window
      wire unused_window = ^{clk, rst_n, apply_i, delta_i};

      assign sq_o   = run_i && in_high_window(32'(ref_cnt_i), 32'(ph_act_i), 32'(PERIOD));
      assign busy_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dab_deadband.sv
module dab_deadband #(
  parameter int DEAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sq_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DW = $clog2(DEAD + 1);

  logic [DW-1:0] age_h;
  logic [DW-1:0] age_l;
  logic          hi_q;
  logic          lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_h <= '0; age_l <= '0; hi_q <= 1'b0; lo_q <= 1'b0;
    end else if (!run_i) begin
      age_h <= '0; age_l <= '0; hi_q <= 1'b0; lo_q <= 1'b0;
    end else begin
      // Count how long each side has been requested, saturating at DEAD
      if (!sq_i)                  age_h <= '0;
      else if (age_h != DW'(DEAD)) age_h <= age_h + 1'b1;
      if (sq_i)                   age_l <= '0;
      else if (age_l != DW'(DEAD)) age_l <= age_l + 1'b1;
      hi_q <= sq_i  && (age_h == DW'(DEAD));
      lo_q <= !sq_i && (age_l == DW'(DEAD));
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  assert_hi_after_lo_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> !$past(lo_q));

  assert_lo_after_hi_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> !$past(hi_q));

endmodule

// File: rtl/dab_pwm_phase.sv
module dab_pwm_phase import dab_pwm_pkg::*; #(
  parameter int         PERIOD    = 16000,
  parameter int         DEAD      = 4,
  parameter lag_style_e LAG_STYLE = LAG_STRETCH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      phase_wr,
  input  logic [$clog2(PERIOD)-1:0] phase_din,
  output logic [7:0]                gate_o
);
  localparam int CW   = $clog2(PERIOD);
  localparam int NBR  = 2;
  localparam int NLEG = 2;

  logic          run_q;
  logic [CW-1:0] ref_cnt;
  logic          ref_wrap;
  logic [CW-1:0] ph_act;
  logic [CW-1:0] delta;
  logic          apply;
  logic          busy;
  logic          sq_ref;
  logic          sq_lag;
  logic [NBR-1:0] bridge_sq;

  // One registered start event launches both bridges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  dab_ref_timebase #(.PERIOD(PERIOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_i(run_q),
    .cnt_o(ref_cnt), .wrap_o(ref_wrap)
  );

  assign sq_ref = run_q && in_high_window(32'(ref_cnt), 32'd0, 32'(PERIOD));

  dab_phase_ctl #(.PERIOD(PERIOD)) u_ph (
    .clk(clk), .rst_n(rst_n), .run_i(run_q),
    .wr_i(phase_wr), .din_i(phase_din),
    .ref_wrap_i(ref_wrap), .busy_i(busy),
    .ph_act_o(ph_act), .delta_o(delta), .apply_o(apply)
  );

  dab_lag_gen #(.PERIOD(PERIOD), .LAG_STYLE(LAG_STYLE)) u_lag (
    .clk(clk), .rst_n(rst_n), .run_i(run_q),
    .ref_cnt_i(ref_cnt), .ph_act_i(ph_act),
    .apply_i(apply), .delta_i(delta),
    .sq_o(sq_lag), .busy_o(busy)
  );

  assign bridge_sq = {sq_lag, sq_ref};

  generate
    for (genvar b = 0; b < NBR; b++) begin : g_bridge
      for (genvar l = 0; l < NLEG; l++) begin : g_leg
        logic leg_sq;
        // Leg B is driven from the inverted bridge wave
        assign leg_sq = (l == 0) ? bridge_sq[b] : !bridge_sq[b];
        dab_deadband #(.DEAD(DEAD)) u_db (
          .clk(clk), .rst_n(rst_n), .run_i(run_q), .sq_i(leg_sq),
          .hi_o(gate_o[4*b + 2*l]), .lo_o(gate_o[4*b + 2*l + 1])
        );
      end
    end
  endgenerate

  assert_gates_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (gate_o == 8'h00));

  assert_legb_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[2] == gate_o[1]) && (gate_o[3] == gate_o[0]) &&
    (gate_o[6] == gate_o[5]) && (gate_o[7] == gate_o[4]));

endmodule

// File: tb/dab_pwm_phase_test.sv
module dab_pwm_phase_test;
  import dab_pwm_pkg::*;

  localparam int P    = 100;
  localparam int HALF = P / 2;
  localparam int D    = 3;
  localparam int PW   = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          phase_wr;
  logic [PW-1:0] phase_din;
  logic [7:0]    gate_s;
  logic [7:0]    gate_w;

  always #10 clk = ~clk;

  dab_pwm_phase #(.PERIOD(P), .DEAD(D), .LAG_STYLE(LAG_STRETCH)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_wr(phase_wr),
    .phase_din(phase_din), .gate_o(gate_s)
  );

  dab_pwm_phase #(.PERIOD(P), .DEAD(D), .LAG_STYLE(LAG_WINDOW)) uut_win (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_wr(phase_wr),
    .phase_din(phase_din), .gate_o(gate_w)
  );

  int n_chk = 0;
  int n_err = 0;

  // Expected values written from the requirements
  function automatic int exp_width();
    return HALF - D;
  endfunction
  function automatic int exp_lag(input int ph);
    return ph % P;
  endfunction
  function automatic int exp_delta(input int from_ph, input int to_ph);
    return (to_ph + P - from_ph) % P;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Edge monitor, sampled on falling clock edges
  int tick = 0;
  int last_r0 [2];
  int last_f0 [2];
  int last_r4 [2];
  int lag     [2];
  int r4_cnt  [2];
  int r0_cnt  [2];
  int odd_cnt [2];
  int odd_val [2];
  int e_p1 = 0, e_wid = 0, e_ovl = 0, e_mir = 0, e_gap = 0;
  logic [7:0] prev [2];

  initial begin
    for (int i = 0; i < 2; i++) begin
      last_r0[i] = 0; last_f0[i] = 0; last_r4[i] = 0; lag[i] = -1;
      r4_cnt[i] = 0; r0_cnt[i] = 0; odd_cnt[i] = 0; odd_val[i] = 0; prev[i] = '0;
    end
  end

  always @(negedge clk) begin
    tick++;
    for (int i = 0; i < 2; i++) begin
      logic [7:0] cur;
      cur = (i == 0) ? gate_s : gate_w;
      if (!en || !rst_n) begin
        last_r0[i] = 0; last_f0[i] = 0; last_r4[i] = 0;
      end else begin
        if (cur[0] && !prev[i][0]) begin
          if (last_r0[i] != 0 && tick - last_r0[i] != P) e_p1++;
          last_r0[i] = tick;
          r0_cnt[i]++;
        end
        if (!cur[0] && prev[i][0]) begin
          if (last_r0[i] != 0 && tick - last_r0[i] != exp_width()) e_wid++;
          last_f0[i] = tick;
        end
        if (cur[1] && !prev[i][1]) begin
          if (last_f0[i] != 0 && tick - last_f0[i] != D) e_gap++;
        end
        if (cur[4] && !prev[i][4]) begin
          if (last_r4[i] != 0 && tick - last_r4[i] != P) begin
            odd_cnt[i]++;
            odd_val[i] = tick - last_r4[i];
          end
          last_r4[i] = tick;
          lag[i] = tick - last_r0[i];
          r4_cnt[i]++;
        end
        if (i == 0 && !cur[4] && prev[i][4]) begin
          if (last_r4[i] != 0 && tick - last_r4[i] != exp_width()) e_wid++;
        end
      end
      if ((cur[0] && cur[1]) || (cur[2] && cur[3]) || (cur[4] && cur[5]) || (cur[6] && cur[7]))
        e_ovl++;
      if (cur[2] != cur[1] || cur[3] != cur[0] || cur[6] != cur[5] || cur[7] != cur[4])
        e_mir++;
      prev[i] = cur;
    end
  end

  task automatic write_phase(input int v);
    @(negedge clk);
    phase_wr  = 1'b1;
    phase_din = PW'(v);
    @(negedge clk);
    phase_wr  = 1'b0;
  endtask

  // Waits for the next bridge 2 rise of both instances
  task automatic next_rise_both(output int l0, output int l1);
    int c0, c1;
    c0 = r4_cnt[0];
    c1 = r4_cnt[1];
    while (r4_cnt[0] == c0 || r4_cnt[1] == c1) @(negedge clk);
    l0 = lag[0];
    l1 = lag[1];
  endtask

  task automatic settle();
    repeat (5 * P) @(negedge clk);
  endtask

  int cur_ph;

  task automatic step(input int nxt);
    int l0, l1, d;
    odd_cnt[0] = 0;
    write_phase(nxt);
    settle();
    next_rise_both(l0, l1);
    check(l0 == exp_lag(nxt), "R6 stretch lag", l0, exp_lag(nxt));
    check(l1 == exp_lag(nxt), "R6 window lag", l1, exp_lag(nxt));
    d = exp_delta(cur_ph, nxt);
    check(odd_cnt[0] == ((d != 0) ? 1 : 0), "R9 stretched period count", odd_cnt[0], (d != 0) ? 1 : 0);
    if (d != 0)
      check(odd_val[0] == P + d, "R9 stretched period length", odd_val[0], P + d);
    cur_ph = nxt;
  endtask

  task automatic step_illegal(input int bad);
    int l0, l1;
    odd_cnt[0] = 0;
    write_phase(bad);
    settle();
    next_rise_both(l0, l1);
    check(l0 == exp_lag(cur_ph), "R7 illegal write stretch lag", l0, exp_lag(cur_ph));
    check(l1 == exp_lag(cur_ph), "R7 illegal write window lag", l1, exp_lag(cur_ph));
    check(odd_cnt[0] == 0, "R7 illegal write no stretch", odd_cnt[0], 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int l0, l1, c;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; phase_wr = 1'b0; phase_din = '0;
    repeat (4) @(negedge clk);
    check(gate_s == 8'h00, "R1 reset idle stretch", int'(gate_s), 0);
    check(gate_w == 8'h00, "R1 reset idle window", int'(gate_w), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Common start with a lag already waiting
    write_phase(30);
    cur_ph = 30;
    en = 1'b1;
    next_rise_both(l0, l1);
    check(l0 == 0, "R5 aligned start stretch", l0, 0);
    check(l1 == 0, "R5 aligned start window", l1, 0);
    settle();
    next_rise_both(l0, l1);
    check(l0 == exp_lag(30), "R6 first lag stretch", l0, exp_lag(30));
    check(l1 == exp_lag(30), "R6 first lag window", l1, exp_lag(30));

    // Directed corners, then random lags
    step(0);
    step(P - 1);
    step(HALF);
    step(1);
    for (int k = 0; k < 8; k++) step(int'($urandom_range(P - 1, 0)));

    step_illegal(P);
    step_illegal(120);

    // R8: write just after a boundary, next bridge 2 rise keeps old lag
    step(20);
    c = r0_cnt[0];
    while (r0_cnt[0] == c) @(negedge clk);
    write_phase(70);
    next_rise_both(l0, l1);
    check(l0 == exp_lag(20), "R8 old lag before boundary stretch", l0, exp_lag(20));
    check(l1 == exp_lag(20), "R8 old lag before boundary window", l1, exp_lag(20));
    settle();
    next_rise_both(l0, l1);
    check(l0 == exp_lag(70), "R8 new lag after boundary stretch", l0, exp_lag(70));
    check(l1 == exp_lag(70), "R8 new lag after boundary window", l1, exp_lag(70));

    // Invariants gathered by the monitor
    check(e_p1 == 0, "R2 bridge 1 period", e_p1, 0);
    check(e_wid == 0, "R2 R9 high pulse width", e_wid, 0);
    check(e_mir == 0, "R3 leg B mirror", e_mir, 0);
    check(e_ovl == 0, "R4 no overlap", e_ovl, 0);
    check(e_gap == 0, "R4 dead gap", e_gap, 0);

    en = 1'b0;
    repeat (3) @(negedge clk);
    check(gate_s == 8'h00, "R1 disable idle stretch", int'(gate_s), 0);
    check(gate_w == 8'h00, "R1 disable idle window", int'(gate_w), 0);

    report();
    $finish;
  end

endmodule